// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a 32-bit register datapath and a data memory that is byte addressed but stores whole 32-bit words. A request carries a base address, a signed 16-bit byte offset, a direction (load or store), an access width (byte, halfword or word), an extension mode and the register data. The block forms the effective address and rounds it down to the word that holds it. For stores it copies the data into every lane of its width and raises a write enable for each lane that is actually written. Accesses that do not sit on a boundary of their own width are flagged as misaligned, and their write enables are suppressed.

Requests enter on a valid/ready channel and leave through one registered output stage on a second valid/ready channel. `req_ready` is high whenever the output stage is empty or is being drained in the same cycle, so a full stage with `out_ready` low stalls the requester. While `out_valid` is high and `out_ready` is low, every output field holds its value. The load return path is separate and combinational. The memory word, the lane offset, the width and the extension mode go in, and the extracted, extended 32-bit value comes out in the same cycle. The consumer normally feeds back the `out_lane`, `out_size` and `out_unsigned` it received with the request.

Lane numbering is big-endian: byte offset 0 is bits 31:24 of the word, and offset 3 is bits 7:0.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits. `out_addr` is that address with bits 1:0 cleared, so word addresses step by 4. `out_lane` is bits 1:0 of the effective address.
- R2: `out_misalign` is 1 for a halfword (size 2'b01) with an odd effective address, or for a word (size 2'b10 or 2'b11) whose effective address has nonzero bits 1:0. A misaligned request drives `out_be` to 4'b0000.
- R3: For an aligned store, `out_be` bit 3 enables bits 31:24 and bit 0 enables bits 7:0. A byte (size 2'b00) at lane k gives 4'b1000 >> k. A halfword at lane 0 gives 4'b1100, and at lane 2 gives 4'b0011. A word gives 4'b1111.
- R4: `out_wdata` repeats `req_wdata[7:0]` in all four lanes for a byte, repeats `req_wdata[15:0]` in both halves for a halfword, and is `req_wdata` unchanged for a word. Only the low 8 or 16 bits of the register data reach memory.
- R5: A load request (`req_is_store`=0) never asserts any bit of `out_be`.
- R6: A byte load (`ld_size`=2'b00) selects the lane given by `ld_lane`. It fills bits 31:8 of `ld_data` with zeros when `ld_unsigned`=1, and with copies of the byte's bit 7 when `ld_unsigned`=0.
- R7: A halfword load selects bits 31:16 when `ld_lane[1]`=0 and bits 15:0 when `ld_lane[1]`=1. It fills bits 31:16 of `ld_data` with zeros (unsigned) or with copies of bit 15 of the halfword (signed).
- R8: A word load (`ld_size` 2'b10 or 2'b11) returns `ld_word` unchanged, whatever `ld_unsigned` is.
- R9: `req_ready` equals `!out_valid || out_ready`. An accepted request appears on the outputs one cycle later. While `out_valid`=1 and `out_ready`=0, all output fields hold their values.
- R10: After reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend on the later load return |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed byte offset |
| req_wdata | input | 32 | Register data for stores |
| out_valid | output | 1 | Output stage holds a request |
| out_ready | input | 1 | Downstream takes the output |
| out_addr | output | 32 | Word-aligned memory address |
| out_lane | output | 2 | Byte offset within the word |
| out_be | output | 4 | Per-lane write enables, bit 3 = bits 31:24 |
| out_wdata | output | 32 | Lane-replicated write data |
| out_is_store | output | 1 | Direction carried along |
| out_size | output | 2 | Width carried along |
| out_unsigned | output | 1 | Extension mode carried along |
| out_misalign | output | 1 | Access violates its width's alignment |
| ld_word | input | 32 | Word returned by memory |
| ld_lane | input | 2 | Byte offset of the load |
| ld_size | input | 2 | Width of the load |
| ld_unsigned | input | 1 | 1 = zero-extend, 0 = sign-extend |
| ld_data | output | 32 | Extracted, extended load result |

## Verification
The bench targets the following corner cases:
- **Negative offsets that borrow across the word boundary.** Zero-extending the offset would land stores in the wrong word.
- **Halfwords at odd lanes and words at lanes 1 to 3.** A missing alignment check would write partial, shifted data into memory.
- **Byte and halfword values with the top bit set, in both extension modes.** A swapped or stuck sign fill would show up in `ld_data[31:8]` or `ld_data[31:16]`.
- **Byte enables at every lane.** A little-endian lane map would mirror the enable pattern against the data.
- **Long stretches with `out_ready` held low, mixed with back-to-back traffic.** A stage that drops or overwrites a held request, or misreports `req_ready`, would lose a request or duplicate one.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } lsu_size_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  lsu_size_e         size,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              misalign
);
  localparam int EXT_W = ADDR_W - OFF_W;

  assign eff_addr = base + {{EXT_W{offset[OFF_W-1]}}, offset};

  always_comb begin
    unique case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = eff_addr[0];
      default: misalign = |eff_addr[LANE_W-1:0];
    endcase
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_lane_pkg::*;
(
  input  logic [LANE_W-1:0] lane,
  input  lsu_size_e         size,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] reg_data,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] mem_data
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [LANE_W-1:0] LID = LANE_W'(l);
    localparam int HI = DATA_W - 1 - 8 * l;
    localparam int HH = 15 - 8 * (l % 2);
    logic hit;

    always_comb begin
      unique case (size)
        SZ_BYTE: hit = (lane == LID);
        SZ_HALF: hit = (lane[LANE_W-1] == LID[LANE_W-1]);
        default: hit = 1'b1;
      endcase
    end

    assign be[LANES-1-l] = wr_en && hit;

    always_comb begin
      unique case (size)
        SZ_BYTE: mem_data[HI -: 8] = reg_data[7:0];
        SZ_HALF: mem_data[HI -: 8] = reg_data[HH -: 8];
        default: mem_data[HI -: 8] = reg_data[HI -: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
(
  input  logic [DATA_W-1:0] word,
  input  logic [LANE_W-1:0] lane,
  input  lsu_size_e         size,
  input  logic              zext,
  output logic [DATA_W-1:0] result
);
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    unique case (lane)
      2'd0: sel_b = word[31:24];
      2'd1: sel_b = word[23:16];
      2'd2: sel_b = word[15:8];
      default: sel_b = word[7:0];
    endcase
    sel_h = lane[1] ? word[15:0] : word[31:16];
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: result = {{(DATA_W-8){~zext & sel_b[7]}}, sel_b};
      SZ_HALF: result = {{(DATA_W-16){~zext & sel_h[15]}}, sel_h};
      default: result = word;
    endcase
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [31:0]       req_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_lane,
  output logic [3:0]        out_be,
  output logic [31:0]       out_wdata,
  output logic              out_is_store,
  output logic [1:0]        out_size,
  output logic              out_unsigned,
  output logic              out_misalign,
  input  logic [31:0]       ld_word,
  input  logic [1:0]        ld_lane,
  input  logic [1:0]        ld_size,
  input  logic              ld_unsigned,
  output logic [31:0]       ld_data
);
  logic [ADDR_W-1:0] ea;
  logic              mis;
  logic [LANES-1:0]  be_c;
  logic [DATA_W-1:0] wd_c;
  logic              accept;

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) agen_i (
    .base(req_base), .offset(req_offset), .size(lsu_size_e'(req_size)),
    .eff_addr(ea), .misalign(mis)
  );

  lsu_store_lanes lanes_i (
    .lane(ea[LANE_W-1:0]), .size(lsu_size_e'(req_size)),
    .wr_en(req_is_store && !mis), .reg_data(req_wdata),
    .be(be_c), .mem_data(wd_c)
  );

  lsu_load_extract extract_i (
    .word(ld_word), .lane(ld_lane), .size(lsu_size_e'(ld_size)),
    .zext(ld_unsigned), .result(ld_data)
  );

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_lane     <= '0;
      out_be       <= '0;
      out_wdata    <= '0;
      out_is_store <= 1'b0;
      out_size     <= '0;
      out_unsigned <= 1'b0;
      out_misalign <= 1'b0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_addr     <= {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
      out_lane     <= ea[LANE_W-1:0];
      out_be       <= be_c;
      out_wdata    <= wd_c;
      out_is_store <= req_is_store;
      out_size     <= req_size;
      out_unsigned <= req_unsigned;
      out_misalign <= mis;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_be)
      && $stable(out_wdata) && $stable(out_misalign)); // R9
  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr[1:0] == 2'b00); // R1
  AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_misalign |-> out_be == 4'b0000); // R2
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_store |-> out_be == 4'b0000); // R5
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_be) != 3) && (out_be != 4'b0110)
      && (out_be != 4'b1010) && (out_be != 4'b0101) && (out_be != 4'b1001)); // R3
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_size == 2'b00 && ld_unsigned |-> ld_data[31:8] == 24'd0); // R6
  AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_size == 2'b01 && ld_unsigned |-> ld_data[31:16] == 16'd0); // R7
endmodule

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_ready, req_is_store = 0, req_unsigned = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_base = 0, req_wdata = 0;
  logic [15:0] req_offset = 0;
  logic out_valid, out_ready = 0, out_is_store, out_unsigned, out_misalign;
  logic [31:0] out_addr, out_wdata;
  logic [1:0] out_lane, out_size;
  logic [3:0] out_be;
  logic [31:0] ld_word = 0, ld_data;
  logic [1:0] ld_lane = 0, ld_size = 0;
  logic ld_unsigned = 0;

  lsu_lane_align dut_i (.*);

  typedef struct packed {
    logic [31:0] addr; logic [1:0] lane; logic [3:0] be; logic [31:0] wd;
    logic st; logic [1:0] sz; logic un; logic mis;
  } exp_t;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic m_valid = 0;
  exp_t m;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model_req(input logic st, input logic [1:0] sz, input logic un,
                                     input logic [31:0] b, input logic [15:0] o, input logic [31:0] d);
    exp_t e;
    logic [31:0] ea;
    ea = b + {{16{o[15]}}, o};
    e.addr = ea & 32'hFFFF_FFFC;
    e.lane = ea[1:0];
    e.st = st; e.sz = sz; e.un = un;
    e.mis = (sz == 2'b01) ? ea[0] : (sz[1] ? (ea[1:0] != 0) : 1'b0);
    if (sz == 2'b00) e.wd = {4{d[7:0]}};
    else if (sz == 2'b01) e.wd = {2{d[15:0]}};
    else e.wd = d;
    e.be = 4'b0000;
    if (st && !e.mis) begin
      if (sz == 2'b00) e.be = 4'b1000 >> ea[1:0];
      else if (sz == 2'b01) e.be = ea[1] ? 4'b0011 : 4'b1100;
      else e.be = 4'b1111;
    end
    return e;
  endfunction

  function automatic logic [31:0] model_ld(input logic [31:0] w, input logic [1:0] ln,
                                          input logic [1:0] sz, input logic un);
    int unsigned b, h;
    b = (w >> (8 * (3 - ln))) & 32'hFF;
    h = ln[1] ? (w & 32'hFFFF) : (w >> 16);
    if (sz == 2'b00) return (!un && b[7]) ? (b | 32'hFFFF_FF00) : b;
    if (sz == 2'b01) return (!un && h[15]) ? (h | 32'hFFFF_0000) : h;
    return w;
  endfunction

  task automatic cyc(input logic v, input logic st, input logic [1:0] sz, input logic un,
                     input logic [31:0] b, input logic [15:0] o, input logic [31:0] d,
                     input logic rdy, input logic [31:0] lw, input logic [1:0] ll,
                     input logic [1:0] ls, input logic lu);
    logic nv;
    exp_t nm;
    logic [31:0] lexp;
    string ltag;
    req_valid = v; req_is_store = st; req_size = sz; req_unsigned = un;
    req_base = b; req_offset = o; req_wdata = d; out_ready = rdy;
    ld_word = lw; ld_lane = ll; ld_size = ls; ld_unsigned = lu;
    #1;
    chk(req_ready == (!m_valid || rdy), "R9 req_ready", 32'(req_ready), 32'(!m_valid || rdy));
    lexp = model_ld(lw, ll, ls, lu);
    ltag = (ls == 2'b00) ? "R6 byte load" : (ls == 2'b01) ? "R7 half load" : "R8 word load";
    chk(ld_data === lexp, ltag, ld_data, lexp);
    nv = m_valid; nm = m;
    if (!m_valid || rdy) begin
      nv = v;
      if (v) nm = model_req(st, sz, un, b, o, d);
    end
    @(posedge clk);
    @(negedge clk);
    m_valid = nv; m = nm;
    chk(out_valid === m_valid, "R9 out_valid", 32'(out_valid), 32'(m_valid));
    if (m_valid) begin
      chk(out_addr === m.addr && out_lane === m.lane, "R1 address", out_addr | 32'(out_lane), m.addr | 32'(m.lane));
      chk(out_misalign === m.mis, "R2 misalign", 32'(out_misalign), 32'(m.mis));
      chk(out_be === m.be, m.st ? "R3 byte enables" : "R5 load enables", 32'(out_be), 32'(m.be));
      chk(out_wdata === m.wd, "R4 write data", out_wdata, m.wd);
      chk({out_is_store, out_size, out_unsigned} === {m.st, m.sz, m.un}, "R9 carried fields",
          32'({out_is_store, out_size, out_unsigned}), 32'({m.st, m.sz, m.un}));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 reset idle", 32'(out_valid), 32'd0);
    // R3 R4: byte stores in every lane
    for (int k = 0; k < 4; k++)
      cyc(1, 1, 2'b00, 0, 32'h1000, 16'(k), 32'hCAFE_BEA5, 1, 32'h8081_7F80, 2'(k), 2'b00, 0);
    // R2 R3: halfword stores aligned and odd
    cyc(1, 1, 2'b01, 0, 32'h2000, 16'd0, 32'h1234_ABCD, 1, 32'h8000_7FFF, 2'd0, 2'b01, 0);
    cyc(1, 1, 2'b01, 0, 32'h2000, 16'd2, 32'h1234_ABCD, 1, 32'h8000_7FFF, 2'd2, 2'b01, 0);
    cyc(1, 1, 2'b01, 0, 32'h2000, 16'd3, 32'h1234_ABCD, 1, 32'h8000_FFFF, 2'd2, 2'b01, 1);
    // R2: words at every lane, with size 11 too
    for (int k = 0; k < 4; k++)
      cyc(1, 1, 2'(2 + (k & 1)), 0, 32'h3001, 16'(k + 3), 32'hDEAD_BEEF, 1, 32'hF00D_1234, 2'(k), 2'(2 + (k & 1)), 1);
    // R1: negative offset borrowing across words
    cyc(1, 1, 2'b10, 0, 32'h0000_0100, 16'hFFFC, 32'h0BAD_F00D, 1, 32'h0, 2'd1, 2'b00, 1);
    cyc(1, 0, 2'b00, 1, 32'h0000_0002, 16'hFFFD, 32'h0, 1, 32'h0, 2'd3, 2'b00, 0);
    // R5: loads of every width
    cyc(1, 0, 2'b10, 0, 32'h40, 16'd0, 32'hFFFF_FFFF, 1, 32'h0000_0080, 2'd3, 2'b00, 0);
    cyc(1, 0, 2'b01, 1, 32'h40, 16'd2, 32'hFFFF_FFFF, 1, 32'h0000_0080, 2'd3, 2'b00, 1);
    // R9: back-pressure hold then drain
    cyc(1, 1, 2'b00, 0, 32'h500, 16'd1, 32'h55, 0, 32'h0, 2'd0, 2'b00, 0);
    for (int k = 0; k < 4; k++)
      cyc(1, 1, 2'b10, 0, 32'h600, 16'd4, 32'h9999_0000, 0, 32'hFF00_0000, 2'd0, 2'b00, k[0]);
    cyc(0, 0, 2'b00, 0, 32'h0, 16'd0, 32'h0, 1, 32'h0, 2'd0, 2'b10, 0);
    cyc(0, 0, 2'b00, 0, 32'h0, 16'd0, 32'h0, 1, 32'h0, 2'd0, 2'b10, 0);
    // random traffic
    for (int n = 0; n < 3000; n++)
      cyc(1'($urandom % 4 != 0), 1'($urandom), 2'($urandom), 1'($urandom), $urandom,
          16'($urandom), $urandom, 1'($urandom % 3 != 0), $urandom, 2'($urandom),
          2'($urandom), 1'($urandom));
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule